// File: doc/BRIEF.md
# Multi-Core Extended Interrupt Router

This block steers 256 level-sensitive interrupt inputs to four cores, with four parent interrupt lines for each core. Each input belongs to a group of 32. A per-group line-select byte chooses the parent line. A per-input core-select byte chooses the target core. An enable vector gates delivery.

For every input the block records the raw pending state and a routed state. The routed state says whether the input is currently delivered, and to which core and line. Each parent line is high exactly while at least one routed input targets it. A routed input stays delivered until one of these events removes it: software acknowledges it, the input falls, the enable bit clears, or the core-select entry moves it to another core.

Software reaches the registers through a byte-addressed port. Accesses are 1, 2, 4 or 8 bytes wide, naturally aligned and little-endian. Every request carries the ID of the requesting core, which selects whose routed status the status window shows and acknowledges. Each request gets a response one cycle later. The node-type and bounce windows only store data.

Top module: `xirq_router`

## Requirements
- R1: A request returns an error response and changes no state in any of these cases: the offset is outside every window, the address is not a multiple of the access size, or it is a write to the pending window. The windows are: node type 0x0A0–0x0BF, line select 0x0C0–0x0C7, enable 0x200–0x21F, bounce 0x280–0x29F, pending 0x300–0x31F (read only), core status 0x400–0x41F, core select 0x800–0x8FF.
- R2: Multi-byte accesses are little-endian. The byte at the lowest address sits in data bits 7:0. Every stored window reads back what was written, at any of the four sizes.
- R3: A rising input sets its pending bit, which reads as bit b of byte 0x300+j for input 8j+b. If the input's enable bit (bit b of byte 0x200+j) is set, the input is also delivered. It then shows in the target core's status (bit b of byte 0x400+j, read by that core) and raises that core's parent line.
- R4: Line-select byte 0x0C0+g serves inputs 32g to 32g+31. With the line binary mode input low, the line is the index of the lowest set bit, and line 0 is used when no bit is set or the index is above 3. With the mode input high, the line is the byte's low two bits. The line is taken at the moment of delivery.
- R5: Core-select byte 0x800+i serves input i. With the core binary mode input low, the core is the index of the lowest set bit, and core 0 is used when no bit is set or the index is 4 or more. With the mode input high, the core is the byte's low two bits.
- R6: Parent output bit 4c+l is high exactly while at least one delivered input targets core c and line l. A line shared by two inputs stays high until both are removed.
- R7: A write that changes an enable bit from 0 to 1 while the input is pending delivers it. A change from 1 to 0 while pending retracts it.
- R8: A write to the status window clears, in the requesting core's status only, each bit written as 1, and lowers the parent line if no other input holds it. Bits written as 0, and writes by other cores, have no effect.
- R9: A core-select write that changes the decoded core of a pending input retracts it from the old core and delivers it on the new core if enabled. A write that leaves the decoded core unchanged has no effect, even if the input had been acknowledged.
- R10: A line-select write does not move inputs that are already delivered.
- R11: A falling input clears its pending bit and its delivered state.
- R12: Reset clears all stored bytes, pending and delivered state, the parent outputs and the response outputs.
- R13: Every request receives exactly one response (rsp_valid) in the cycle after it. Write responses carry zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 256 | Level-sensitive interrupt inputs |
| mode_line_bin | input | 1 | Line-select bytes decode as binary when high, lowest-set-bit when low |
| mode_core_bin | input | 1 | Core-select bytes decode as binary when high, lowest-set-bit when low |
| req_valid | input | 1 | Register request strobe |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the access |
| req_size | input | 2 | log2 of the access size in bytes |
| req_core | input | 2 | ID of the requesting core |
| req_wdata | input | 64 | Write data, little-endian |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Request rejected |
| rsp_rdata | output | 64 | Read data, zero-extended |
| core_irq | output | 16 | Parent lines, bit 4*core+line |

## Verification
A corrupted routed core or line field would light the wrong parent bit. That shows at the ports in the cycle after the event that delivered the input. If the cleared routed bit failed to follow an acknowledge, an enable clear or a falling input, the parent line would stay high. A status read from the owning core one cycle later would also disagree. Damage to a stored byte only shows when the byte is read back, or when a later delivery uses the byte to pick a core or line. For that reason every routing check is paired with a readback of the status or pending window.

// File: rtl/xirq_pkg.sv
`timescale 1ns/1ps
package xirq_pkg;
    localparam int NUM_IRQ   = 256;
    localparam int NUM_CORE  = 4;
    localparam int NUM_LINE  = 4;
    localparam int GROUP     = 32;
    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 64;
    localparam int LANES     = DATA_W / 8;
    localparam int CORE_W    = $clog2(NUM_CORE);
    localparam int LINE_W    = $clog2(NUM_LINE);
    localparam int NUM_GROUP = NUM_IRQ / GROUP;
    localparam int VEC_BYTES = NUM_IRQ / 8;
    localparam int NODE_BYTES   = 32;
    localparam int BOUNCE_BYTES = 32;
    localparam int CMAP_BYTES   = NUM_IRQ;
    localparam int OFF_W     = $clog2(CMAP_BYTES);
    localparam int NUM_OUT   = NUM_CORE * NUM_LINE;

    // window bases; software depends on these offsets
    localparam logic [ADDR_W-1:0] BASE_NODE   = 12'h0A0;
    localparam logic [ADDR_W-1:0] BASE_LSEL   = 12'h0C0;
    localparam logic [ADDR_W-1:0] BASE_EN     = 12'h200;
    localparam logic [ADDR_W-1:0] BASE_BOUNCE = 12'h280;
    localparam logic [ADDR_W-1:0] BASE_PEND   = 12'h300;
    localparam logic [ADDR_W-1:0] BASE_STAT   = 12'h400;
    localparam logic [ADDR_W-1:0] BASE_CSEL   = 12'h800;

    typedef enum logic [2:0] {
        WIN_NONE, WIN_NODE, WIN_LSEL, WIN_EN, WIN_BOUNCE, WIN_PEND, WIN_STAT, WIN_CSEL
    } win_e;

    typedef struct packed {
        win_e             win;
        logic [OFF_W-1:0] off;
        logic             bad;
    } acc_decode_t;

    typedef struct packed {
        logic              pending;
        logic              routed;
        logic [CORE_W-1:0] core;
        logic [LINE_W-1:0] line;
    } slot_t;

    function automatic logic [2:0] low_bit(logic [7:0] b);
        logic [2:0] r;
        r = '0;
        for (int k = 7; k >= 0; k--) begin
            if (b[k]) r = 3'(k);
        end
        return r;
    endfunction

    function automatic logic [LINE_W-1:0] pick_line(logic [7:0] b, logic binary);
        logic [2:0] idx;
        idx = low_bit(b);
        if (binary) return b[LINE_W-1:0];
        if (int'(idx) < NUM_LINE) return idx[LINE_W-1:0];
        return '0;
    endfunction

    function automatic logic [CORE_W-1:0] pick_core(logic [7:0] b, logic binary);
        logic [2:0] idx;
        idx = low_bit(b);
        if (binary) return b[CORE_W-1:0];
        if (int'(idx) < NUM_CORE) return idx[CORE_W-1:0];
        return '0;
    endfunction
endpackage

// File: rtl/xirq_addr_dec.sv
`timescale 1ns/1ps
module xirq_addr_dec
    import xirq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              we,
    output acc_decode_t       dec
);
    function automatic logic inwin(logic [ADDR_W-1:0] a, logic [ADDR_W-1:0] base, int len);
        return (a >= base) && (a < base + ADDR_W'(len));
    endfunction

    win_e              win;
    logic [ADDR_W-1:0] base;
    logic              misalign;

    always_comb begin
        win  = WIN_NONE;
        base = '0;
        if (inwin(addr, BASE_NODE, NODE_BYTES)) begin
            win = WIN_NODE;   base = BASE_NODE;
        end else if (inwin(addr, BASE_LSEL, NUM_GROUP)) begin
            win = WIN_LSEL;   base = BASE_LSEL;
        end else if (inwin(addr, BASE_EN, VEC_BYTES)) begin
            win = WIN_EN;     base = BASE_EN;
        end else if (inwin(addr, BASE_BOUNCE, BOUNCE_BYTES)) begin
            win = WIN_BOUNCE; base = BASE_BOUNCE;
        end else if (inwin(addr, BASE_PEND, VEC_BYTES)) begin
            win = WIN_PEND;   base = BASE_PEND;
        end else if (inwin(addr, BASE_STAT, VEC_BYTES)) begin
            win = WIN_STAT;   base = BASE_STAT;
        end else if (inwin(addr, BASE_CSEL, CMAP_BYTES)) begin
            win = WIN_CSEL;   base = BASE_CSEL;
        end
        misalign = |(addr & ((ADDR_W'(1) << size) - ADDR_W'(1)));
        dec.win  = win;
        dec.off  = OFF_W'(addr - base);
        dec.bad  = misalign || (win == WIN_NONE) || (we && win == WIN_PEND);
    end
endmodule

// File: rtl/xirq_byte_store.sv
`timescale 1ns/1ps
module xirq_byte_store
    import xirq_pkg::*;
#(
    parameter int BYTES = 32,
    parameter int OW    = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  logic [OW-1:0]      off,
    input  logic [1:0]         size,
    input  logic [DATA_W-1:0]  wdata,
    output logic [BYTES*8-1:0] q,
    output logic [BYTES*8-1:0] nxt
);
    always_comb begin
        nxt = q;
        if (wr) begin
            for (int k = 0; k < LANES; k++) begin
                if (k < (1 << size) && (int'(off) + k) < BYTES)
                    nxt[(int'(off) + k)*8 +: 8] = wdata[k*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end
endmodule

// File: rtl/xirq_slot.sv
`timescale 1ns/1ps
module xirq_slot
    import xirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lvl,
    input  logic              en_old,
    input  logic              en_new,
    input  logic              cm_wr,
    input  logic [CORE_W-1:0] core_old,
    input  logic [CORE_W-1:0] core_new,
    input  logic [LINE_W-1:0] line_now,
    input  logic              ack,
    input  logic [CORE_W-1:0] req_core,
    output slot_t             state
);
    slot_t nx;
    logic  rise, fall;

    assign rise = lvl && !state.pending;
    assign fall = !lvl && state.pending;

    always_comb begin
        nx = state;
        nx.pending = lvl;
        // acknowledge acts on the state delivered before this cycle
        if (ack && state.routed && state.core == req_core) nx.routed = 1'b0;
        if (fall) nx.routed = 1'b0;
        if (rise && en_new) begin
            nx.routed = 1'b1;
            nx.core   = core_new;
            nx.line   = line_now;
        end
        if (nx.pending && en_new && !en_old) begin
            nx.routed = 1'b1;
            nx.core   = core_new;
            nx.line   = line_now;
        end
        if (nx.pending && !en_new && en_old) nx.routed = 1'b0;
        if (nx.pending && cm_wr && core_new != core_old) begin
            nx.routed = en_new;
            nx.core   = core_new;
            nx.line   = line_now;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= '0;
        else     state <= nx;
    end
endmodule

// File: rtl/xirq_router.sv
`timescale 1ns/1ps
module xirq_router
    import xirq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_IRQ-1:0]  irq_in,
    input  logic                mode_line_bin,
    input  logic                mode_core_bin,
    input  logic                req_valid,
    input  logic                req_we,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [1:0]          req_size,
    input  logic [CORE_W-1:0]   req_core,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rsp_valid,
    output logic                rsp_err,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic [NUM_OUT-1:0]  core_irq
);
    localparam int NODE_OW = $clog2(NODE_BYTES);
    localparam int LSEL_OW = $clog2(NUM_GROUP);
    localparam int EN_OW   = $clog2(VEC_BYTES);
    localparam int BNC_OW  = $clog2(BOUNCE_BYTES);

    acc_decode_t dec;
    logic        acc_ok, wr_ok;

    xirq_addr_dec u_dec (
        .addr (req_addr),
        .size (req_size),
        .we   (req_we),
        .dec  (dec)
    );

    assign acc_ok = req_valid && !dec.bad;
    assign wr_ok  = acc_ok && req_we;

    logic [NODE_BYTES*8-1:0]   node_q, node_nxt;
    logic [NUM_GROUP*8-1:0]    lsel_q, lsel_nxt;
    logic [NUM_IRQ-1:0]        en_q, en_nxt;
    logic [BOUNCE_BYTES*8-1:0] bnc_q, bnc_nxt;
    logic [CMAP_BYTES*8-1:0]   csel_q, csel_nxt;

    xirq_byte_store #(.BYTES(NODE_BYTES), .OW(NODE_OW)) u_node (
        .clk, .rst, .wr(wr_ok && dec.win == WIN_NODE), .off(dec.off[NODE_OW-1:0]),
        .size(req_size), .wdata(req_wdata), .q(node_q), .nxt(node_nxt)
    );
    xirq_byte_store #(.BYTES(NUM_GROUP), .OW(LSEL_OW)) u_lsel (
        .clk, .rst, .wr(wr_ok && dec.win == WIN_LSEL), .off(dec.off[LSEL_OW-1:0]),
        .size(req_size), .wdata(req_wdata), .q(lsel_q), .nxt(lsel_nxt)
    );
    xirq_byte_store #(.BYTES(VEC_BYTES), .OW(EN_OW)) u_en (
        .clk, .rst, .wr(wr_ok && dec.win == WIN_EN), .off(dec.off[EN_OW-1:0]),
        .size(req_size), .wdata(req_wdata), .q(en_q), .nxt(en_nxt)
    );
    xirq_byte_store #(.BYTES(BOUNCE_BYTES), .OW(BNC_OW)) u_bnc (
        .clk, .rst, .wr(wr_ok && dec.win == WIN_BOUNCE), .off(dec.off[BNC_OW-1:0]),
        .size(req_size), .wdata(req_wdata), .q(bnc_q), .nxt(bnc_nxt)
    );
    xirq_byte_store #(.BYTES(CMAP_BYTES), .OW(OFF_W)) u_csel (
        .clk, .rst, .wr(wr_ok && dec.win == WIN_CSEL), .off(dec.off),
        .size(req_size), .wdata(req_wdata), .q(csel_q), .nxt(csel_nxt)
    );

    // per-input write strobes from the status and core-select windows
    logic [NUM_IRQ-1:0]    ack_vec;
    logic [CMAP_BYTES-1:0] cm_touch;

    always_comb begin : p_strobe
        int idx;
        ack_vec  = '0;
        cm_touch = '0;
        for (int k = 0; k < LANES; k++) begin
            idx = int'(dec.off) + k;
            if (wr_ok && k < (1 << req_size)) begin
                if (dec.win == WIN_STAT && idx < VEC_BYTES)
                    ack_vec[idx*8 +: 8] = req_wdata[k*8 +: 8];
                if (dec.win == WIN_CSEL && idx < CMAP_BYTES)
                    cm_touch[idx] = 1'b1;
            end
        end
    end

    logic [LINE_W-1:0] grp_line [NUM_GROUP];
    slot_t             slot     [NUM_IRQ];

    for (genvar g = 0; g < NUM_GROUP; g++) begin : g_line
        assign grp_line[g] = pick_line(lsel_q[g*8 +: 8], mode_line_bin);
    end

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_slot
        logic [CORE_W-1:0] c_old, c_new;
        assign c_old = pick_core(csel_q[i*8 +: 8], mode_core_bin);
        assign c_new = pick_core(csel_nxt[i*8 +: 8], mode_core_bin);
        xirq_slot u_slot (
            .clk      (clk),
            .rst      (rst),
            .lvl      (irq_in[i]),
            .en_old   (en_q[i]),
            .en_new   (en_nxt[i]),
            .cm_wr    (cm_touch[i]),
            .core_old (c_old),
            .core_new (c_new),
            .line_now (grp_line[i / GROUP]),
            .ack      (ack_vec[i]),
            .req_core (req_core),
            .state    (slot[i])
        );
    end

    logic [NUM_IRQ-1:0] pend_vec, stat_vec;

    always_comb begin
        core_irq = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            pend_vec[i] = slot[i].pending;
            stat_vec[i] = slot[i].routed && (slot[i].core == req_core);
            if (slot[i].routed)
                core_irq[int'(slot[i].core)*NUM_LINE + int'(slot[i].line)] = 1'b1;
        end
    end

    logic [DATA_W-1:0] rdata;

    always_comb begin : p_rd
        int         idx;
        logic [7:0] b;
        rdata = '0;
        for (int k = 0; k < LANES; k++) begin
            idx = int'(dec.off) + k;
            b   = '0;
            if (k < (1 << req_size)) begin
                case (dec.win)
                    WIN_NODE:   if (idx < NODE_BYTES)   b = node_q[idx*8 +: 8];
                    WIN_LSEL:   if (idx < NUM_GROUP)    b = lsel_q[idx*8 +: 8];
                    WIN_EN:     if (idx < VEC_BYTES)    b = en_q[idx*8 +: 8];
                    WIN_BOUNCE: if (idx < BOUNCE_BYTES) b = bnc_q[idx*8 +: 8];
                    WIN_PEND:   if (idx < VEC_BYTES)    b = pend_vec[idx*8 +: 8];
                    WIN_STAT:   if (idx < VEC_BYTES)    b = stat_vec[idx*8 +: 8];
                    WIN_CSEL:   if (idx < CMAP_BYTES)   b = csel_q[idx*8 +: 8];
                    default:    b = '0;
                endcase
            end
            rdata[k*8 +: 8] = b;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && dec.bad;
            rsp_rdata <= (acc_ok && !req_we) ? rdata : '0;
        end
    end
endmodule

// File: rtl/xirq_router_chk.sv
`timescale 1ns/1ps
module xirq_router_chk
    import xirq_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [NUM_IRQ-1:0] irq_in,
    input logic               req_valid,
    input logic [ADDR_W-1:0]  req_addr,
    input logic [1:0]         req_size,
    input logic               rsp_valid,
    input logic               rsp_err,
    input logic [NUM_OUT-1:0] core_irq
);
    // R13
    rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R13
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R1
    misalign_err_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && |(req_addr & ((ADDR_W'(1) << req_size) - ADDR_W'(1)))) |=> rsp_err);

    // R11
    quiet_inputs_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_in == '0) |=> (core_irq == '0));

    // R12
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (core_irq == '0 && !rsp_valid));
endmodule

bind xirq_router xirq_router_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_in    (irq_in),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .core_irq  (core_irq)
);

// File: tb/test_xirq_router.sv
`timescale 1ns/1ps
module test_xirq_router;
    import xirq_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                rst;
    logic [NUM_IRQ-1:0]  irq_in;
    logic                mode_line_bin, mode_core_bin;
    logic                req_valid, req_we;
    logic [ADDR_W-1:0]   req_addr;
    logic [1:0]          req_size;
    logic [CORE_W-1:0]   req_core;
    logic [DATA_W-1:0]   req_wdata;
    logic                rsp_valid, rsp_err;
    logic [DATA_W-1:0]   rsp_rdata;
    logic [NUM_OUT-1:0]  core_irq;

    xirq_router i_xirq_router (
        .clk, .rst, .irq_in, .mode_line_bin, .mode_core_bin,
        .req_valid, .req_we, .req_addr, .req_size, .req_core, .req_wdata,
        .rsp_valid, .rsp_err, .rsp_rdata, .core_irq
    );

    typedef struct {
        logic [DATA_W-1:0] data;
        logic              err;
        string             tag;
    } exp_t;

    exp_t expq[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    // scoreboard monitor
    always @(negedge clk) begin
        if (rsp_valid) begin
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL R13 unexpected response act=1 exp=0");
            end else begin
                exp_t e;
                e = expq.pop_front();
                if (rsp_rdata !== e.data || rsp_err !== e.err) begin
                    errors++;
                    $display("FAIL %s rsp act=%h/%b exp=%h/%b", e.tag, rsp_rdata, rsp_err, e.data, e.err);
                end
            end
        end
    end

    task automatic access(input bit we, input logic [ADDR_W-1:0] a, input logic [1:0] sz,
                          input logic [CORE_W-1:0] core, input logic [DATA_W-1:0] wd,
                          input logic [DATA_W-1:0] ed, input bit ee, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_size = sz;
        req_core = core; req_wdata = wd;
        e.data = ed; e.err = ee; e.tag = tag;
        expq.push_back(e);
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [1:0] sz,
                      input logic [DATA_W-1:0] wd, input logic [CORE_W-1:0] core, input string tag);
        access(1'b1, a, sz, core, wd, '0, 1'b0, tag);
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [1:0] sz,
                      input logic [CORE_W-1:0] core, input logic [DATA_W-1:0] ed, input string tag);
        access(1'b0, a, sz, core, '0, ed, 1'b0, tag);
    endtask

    task automatic chk_out(input logic [NUM_OUT-1:0] exp_v, input string tag);
        @(negedge clk);
        checks++;
        if (core_irq !== exp_v) begin
            errors++;
            $display("FAIL %s core_irq act=%h exp=%h", tag, core_irq, exp_v);
        end
    endtask

    task automatic set_in(input int i, input logic v);
        @(negedge clk);
        irq_in[i] = v;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R13 watchdog act=hung exp=done");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; irq_in = '0; mode_line_bin = 1'b0; mode_core_bin = 1'b0;
        req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_size = '0;
        req_core = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12 reset state
        chk_out(16'h0000, "R12");
        rd(12'h200, 2'd3, 2'd0, 64'h0, "R12");
        rd(12'h800, 2'd3, 2'd0, 64'h0, "R12");

        // R1 illegal requests
        access(1'b0, 12'h202, 2'd2, 2'd0, '0, '0, 1'b1, "R1");
        access(1'b0, 12'h100, 2'd0, 2'd0, '0, '0, 1'b1, "R1");
        access(1'b0, 12'h0C8, 2'd0, 2'd0, '0, '0, 1'b1, "R1");
        access(1'b1, 12'h300, 2'd0, 2'd0, 64'hFF, '0, 1'b1, "R1");
        rd(12'h300, 2'd0, 2'd0, 64'h0, "R1");
        access(1'b1, 12'h201, 2'd1, 2'd0, 64'hFFFF, '0, 1'b1, "R1");
        rd(12'h200, 2'd3, 2'd0, 64'h0, "R1");

        // R2 little-endian storage
        wr(12'h0A8, 2'd3, 64'h1122334455667788, 2'd0, "R2");
        rd(12'h0AC, 2'd1, 2'd0, 64'h3344, "R2");
        rd(12'h0A8, 2'd3, 2'd0, 64'h1122334455667788, "R2");
        wr(12'h284, 2'd2, 64'hCAFEF00D, 2'd1, "R2");
        rd(12'h286, 2'd0, 2'd0, 64'hFE, "R2");
        rd(12'h284, 2'd2, 2'd3, 64'hCAFEF00D, "R2");

        // R3 R4 R5: input 5 -> core 2 (one-hot 0x04), line 1 (one-hot 0x02)
        wr(12'h805, 2'd0, 64'h04, 2'd0, "R5");
        wr(12'h0C0, 2'd0, 64'h02, 2'd0, "R4");
        wr(12'h200, 2'd0, 64'h20, 2'd0, "R3");
        set_in(5, 1'b1);
        chk_out(16'h0200, "R3");
        rd(12'h400, 2'd0, 2'd2, 64'h20, "R3");
        rd(12'h400, 2'd0, 2'd0, 64'h00, "R3");
        rd(12'h300, 2'd0, 2'd1, 64'h20, "R3");

        // R4 fallback: empty byte -> line 0; bit 4 -> line 0
        wr(12'h840, 2'd0, 64'h00, 2'd0, "R5");
        wr(12'h208, 2'd0, 64'h01, 2'd0, "R4");
        set_in(64, 1'b1);
        chk_out(16'h0201, "R4");
        wr(12'h0C3, 2'd0, 64'h10, 2'd0, "R4");
        wr(12'h860, 2'd0, 64'h02, 2'd0, "R5");
        wr(12'h20C, 2'd0, 64'h01, 2'd0, "R4");
        set_in(96, 1'b1);
        chk_out(16'h0211, "R4");

        // R11 falling inputs
        set_in(64, 1'b0);
        set_in(96, 1'b0);
        chk_out(16'h0200, "R11");
        rd(12'h308, 2'd0, 2'd0, 64'h00, "R11");
        rd(12'h408, 2'd0, 2'd0, 64'h00, "R11");

        // R6 R8 shared line and acknowledge
        wr(12'h806, 2'd0, 64'h04, 2'd0, "R6");
        wr(12'h200, 2'd0, 64'h60, 2'd0, "R6");
        set_in(6, 1'b1);
        chk_out(16'h0200, "R6");
        rd(12'h400, 2'd0, 2'd2, 64'h60, "R6");
        wr(12'h400, 2'd0, 64'h60, 2'd0, "R8");
        rd(12'h400, 2'd0, 2'd2, 64'h60, "R8");
        wr(12'h400, 2'd0, 64'h20, 2'd2, "R8");
        chk_out(16'h0200, "R6");
        rd(12'h400, 2'd0, 2'd2, 64'h40, "R8");
        wr(12'h400, 2'd0, 64'h40, 2'd2, "R8");
        chk_out(16'h0000, "R8");

        // R7 enable edges while pending
        wr(12'h200, 2'd0, 64'h00, 2'd0, "R7");
        chk_out(16'h0000, "R7");
        wr(12'h200, 2'd0, 64'h20, 2'd0, "R7");
        chk_out(16'h0200, "R7");
        wr(12'h200, 2'd0, 64'h00, 2'd0, "R7");
        chk_out(16'h0000, "R7");
        wr(12'h200, 2'd0, 64'h20, 2'd0, "R7");
        chk_out(16'h0200, "R7");

        // R9 core move
        wr(12'h805, 2'd0, 64'h01, 2'd0, "R9");
        chk_out(16'h0002, "R9");
        rd(12'h400, 2'd0, 2'd0, 64'h20, "R9");
        rd(12'h400, 2'd0, 2'd2, 64'h00, "R9");
        wr(12'h400, 2'd0, 64'h20, 2'd0, "R8");
        chk_out(16'h0000, "R8");
        wr(12'h805, 2'd0, 64'h03, 2'd0, "R9");
        chk_out(16'h0000, "R9");
        wr(12'h805, 2'd0, 64'h08, 2'd0, "R9");
        chk_out(16'h2000, "R9");

        // R10 line select change keeps delivered input
        wr(12'h0C0, 2'd0, 64'h08, 2'd0, "R10");
        chk_out(16'h2000, "R10");
        set_in(5, 1'b0);
        chk_out(16'h0000, "R11");
        rd(12'h300, 2'd0, 2'd0, 64'h40, "R11");
        set_in(5, 1'b1);
        chk_out(16'h8000, "R10");

        // R4 R5 binary modes: input 40 line 2, core 1; input 41 core 3
        mode_line_bin = 1'b1;
        mode_core_bin = 1'b1;
        wr(12'h0C1, 2'd0, 64'h06, 2'd0, "R4");
        wr(12'h828, 2'd1, 64'h0301, 2'd0, "R5");
        rd(12'h829, 2'd0, 2'd0, 64'h03, "R2");
        wr(12'h205, 2'd0, 64'h03, 2'd0, "R5");
        set_in(40, 1'b1);
        chk_out(16'h8040, "R4");
        set_in(41, 1'b1);
        chk_out(16'hC040, "R5");

        // R2 R7 eight-byte enable write retracts input 5 only
        wr(12'h200, 2'd3, 64'h0000_0300_0000_0000, 2'd0, "R7");
        chk_out(16'h4040, "R7");
        rd(12'h204, 2'd2, 2'd0, 64'h0000_0300, "R2");

        // R12 reset with inputs still high: nothing enabled afterwards
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk_out(16'h0000, "R12");
        rd(12'h205, 2'd0, 2'd0, 64'h00, "R12");
        rd(12'h0C0, 2'd3, 2'd0, 64'h00, "R12");

        repeat (3) @(negedge clk);
        checks++;
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL R13 missing responses act=%0d exp=0", expq.size());
        end
        done = 1;
        summary();
        $finish;
    end
endmodule